// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a storage register of configurable width (eight bits by default). On each rising clock edge it does one of four things, chosen by a two-bit select: keep its contents, move every bit one place toward the top, move every bit one place toward the bottom, or capture a whole word from its parallel port. A serial input feeds the vacated end in each shift direction. The lowest and highest stored bits also leave the block on their own outputs, so several copies can be joined into a longer register by wiring each one's end bits to its neighbours' serial inputs.

The parallel port is one shared bus on the board: the same lines carry load data in and the stored word out. Inside the chip it is split into an input word, an output word and a single drive-enable. The port drives only while two active-low enables are both low, and it stops driving whenever load is selected, so a load never captures the block's own output. An active-low clear empties the register at once, without a clock edge, and takes priority over the clock and the select.

Top module: `uni_shift_reg`

## Requirements
- R1: While `clr_n` is low, every stored bit is 0 from that moment on, with no clock edge needed, whatever `sel` and the clock do.
- R2: With `sel` = 2'b00 the stored word is unchanged by a rising clock edge.
- R3: With `sel` = 2'b01 a rising edge moves bit i into bit i+1 and loads `sin_lsb` into bit 0 (shift toward the top bit).
- R4: With `sel` = 2'b10 a rising edge moves bit i+1 into bit i and loads `sin_msb` into the top bit (shift toward bit 0).
- R5: With `sel` = 2'b11 a rising edge captures `pio_in` bit n into stored bit n.
- R6: `pio_oe` is high exactly when `oe_a_n` and `oe_b_n` are both low and `sel` is not 2'b11; it follows these inputs without a clock edge, so the port is never driven while load is selected.
- R7: `pio_out` always equals the stored word, and `q_lo` / `q_hi` always equal stored bit 0 / the top stored bit, whether or not the port is driving.
- R8: Hold, both shifts, load and clear behave the same while `pio_oe` is low; two instances chained end bit to serial input act as one register of twice the width in both shift directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Operation select: 00 keep, 01 shift up, 10 shift down, 11 load |
| sin_lsb | input | 1 | Serial bit entering bit 0 on an upward shift |
| sin_msb | input | 1 | Serial bit entering the top bit on a downward shift |
| oe_a_n | input | 1 | Port drive enable, active low |
| oe_b_n | input | 1 | Second port drive enable, active low |
| pio_in | input | WIDTH | Value seen on the shared port lines |
| pio_out | output | WIDTH | Stored word presented to the shared port |
| pio_oe | output | 1 | High when the block drives the shared port |
| q_lo | output | 1 | Stored bit 0, always valid |
| q_hi | output | 1 | Top stored bit, always valid |

## Verification
The port drive-enable and the clear act within the same cycle, so the bench samples `pio_oe` one nanosecond after changing the select and enables at the falling edge, and samples the cleared word one nanosecond after pulling `clr_n` low between edges. Every clocked operation lands on the one rising edge that follows the inputs, so the bench applies inputs at the falling edge, computes the next word from the requirement, and compares `pio_out`, `q_lo` and `q_hi` one nanosecond after that rising edge. The bench resolves the shared bus itself, feeding the block's own output back to `pio_in` whenever `pio_oe` is high, so a design that drove during load would capture the wrong word.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DN   = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;

    // One-hot choice of where each stored bit takes its next value from.
    typedef struct packed {
        logic keep;
        logic from_lower;
        logic from_upper;
        logic from_pin;
    } slice_src_t;

    function automatic slice_src_t decode_src(mode_e m);
        slice_src_t s;
        s = '0;
        unique case (m)
            MODE_HOLD: s.keep       = 1'b1;
            MODE_UP:   s.from_lower = 1'b1;
            MODE_DN:   s.from_upper = 1'b1;
            MODE_LOAD: s.from_pin   = 1'b1;
            default:   s.keep       = 1'b1;
        endcase
        return s;
    endfunction

    function automatic logic may_drive(logic en_a_n, logic en_b_n, mode_e m);
        return !(en_a_n || en_b_n) && (m != MODE_LOAD);
    endfunction

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  logic [1:0] sel,
    output mode_e      mode,
    output slice_src_t src
);

    always_comb begin
        mode = mode_e'(sel);
        src  = decode_src(mode_e'(sel));
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!clr_n)
        $onehot(src)) else $error("slice source not one-hot"); // R2

endmodule

// File: rtl/usr_bit_slice.sv
module usr_bit_slice
    import usr_pkg::*;
(
    input  slice_src_t src,
    input  logic       self_bit,
    input  logic       lower_bit,
    input  logic       upper_bit,
    input  logic       pin_bit,
    output logic       nxt_bit
);

    always_comb begin
        nxt_bit = self_bit;
        if (src.from_lower)      nxt_bit = lower_bit;
        else if (src.from_upper) nxt_bit = upper_bit;
        else if (src.from_pin)   nxt_bit = pin_bit;
    end

endmodule

// File: rtl/usr_store.sv
module usr_store
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  mode_e            mode,
    input  logic             sin_lsb,
    input  logic             sin_msb,
    input  logic [WIDTH-1:0] pin,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= d;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_HOLD) |=> $stable(q)) else $error("hold changed word"); // R2

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_UP) |=> (q == {$past(q[TOP-1:0]), $past(sin_lsb)}))
        else $error("upward shift wrong"); // R3

    AST_SHIFT_DN: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_DN) |=> (q == {$past(sin_msb), $past(q[TOP:1])}))
        else $error("downward shift wrong"); // R4

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_LOAD) |=> (q == $past(pin))) else $error("load wrong"); // R5

endmodule

// File: rtl/usr_port_ctrl.sv
module usr_port_ctrl
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  mode_e            mode,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] pio_out,
    output logic             pio_oe
);

    always_comb begin
        pio_out = word;
        pio_oe  = may_drive(oe_a_n, oe_b_n, mode);
    end

    AST_NO_DRIVE_ON_LOAD: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == MODE_LOAD) |-> !pio_oe) else $error("port driven during load"); // R6

    AST_DRIVE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!clr_n)
        pio_oe |-> (!oe_a_n && !oe_b_n)) else $error("port driven while disabled"); // R6

endmodule

// File: rtl/uni_shift_reg.sv
module uni_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       sel,
    input  logic             sin_lsb,
    input  logic             sin_msb,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] pio_in,
    output logic [WIDTH-1:0] pio_out,
    output logic             pio_oe,
    output logic             q_lo,
    output logic             q_hi
);

    localparam int TOP = WIDTH - 1;

    mode_e            mode;
    slice_src_t       src;
    logic [WIDTH-1:0] state_d;
    logic [WIDTH-1:0] state_q;

    usr_mode_decode u_dec (
        .clk  (clk),
        .clr_n(clr_n),
        .sel  (sel),
        .mode (mode),
        .src  (src)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic lower_src;
        logic upper_src;
        if (i == 0) begin : g_lo_end
            assign lower_src = sin_lsb;
        end else begin : g_lo_mid
            assign lower_src = state_q[i-1];
        end
        if (i == TOP) begin : g_hi_end
            assign upper_src = sin_msb;
        end else begin : g_hi_mid
            assign upper_src = state_q[i+1];
        end
        usr_bit_slice u_slice (
            .src      (src),
            .self_bit (state_q[i]),
            .lower_bit(lower_src),
            .upper_bit(upper_src),
            .pin_bit  (pio_in[i]),
            .nxt_bit  (state_d[i])
        );
    end

    usr_store #(.WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .clr_n  (clr_n),
        .mode   (mode),
        .sin_lsb(sin_lsb),
        .sin_msb(sin_msb),
        .pin    (pio_in),
        .d      (state_d),
        .q      (state_q)
    );

    usr_port_ctrl #(.WIDTH(WIDTH)) u_port (
        .clk    (clk),
        .clr_n  (clr_n),
        .mode   (mode),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .word   (state_q),
        .pio_out(pio_out),
        .pio_oe (pio_oe)
    );

    assign q_lo = state_q[0];
    assign q_hi = state_q[TOP];

    AST_END_BITS: assert property (@(posedge clk) disable iff (!clr_n)
        (q_lo == pio_out[0]) && (q_hi == pio_out[TOP])) else $error("end bits differ"); // R7

endmodule

// File: tb/tb_uni_shift_reg.sv
module tb_uni_shift_reg;

    localparam int W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         clr_n, sin_lsb, sin_msb, oe_a_n, oe_b_n;
    logic [1:0]   sel;
    logic [W-1:0] ext_drive;
    logic [W-1:0] bus;
    logic [W-1:0] pio_out;
    logic         pio_oe, q_lo, q_hi;

    // shared-bus resolution: the block's output wins when it drives
    assign bus = pio_oe ? pio_out : ext_drive;

    uni_shift_reg #(.WIDTH(W)) dut (
        .clk(clk), .clr_n(clr_n), .sel(sel), .sin_lsb(sin_lsb), .sin_msb(sin_msb),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pio_in(bus), .pio_out(pio_out),
        .pio_oe(pio_oe), .q_lo(q_lo), .q_hi(q_hi)
    );

    // two-instance chain, port disabled
    logic [1:0]   c_sel;
    logic         c_sl, c_sm;
    logic [W-1:0] ca_out, cb_out;
    logic         ca_oe, cb_oe, ca_lo, ca_hi, cb_lo, cb_hi;

    uni_shift_reg #(.WIDTH(W)) chain_a (
        .clk(clk), .clr_n(clr_n), .sel(c_sel), .sin_lsb(c_sl), .sin_msb(cb_lo),
        .oe_a_n(1'b1), .oe_b_n(1'b1), .pio_in('0), .pio_out(ca_out),
        .pio_oe(ca_oe), .q_lo(ca_lo), .q_hi(ca_hi)
    );
    uni_shift_reg #(.WIDTH(W)) chain_b (
        .clk(clk), .clr_n(clr_n), .sel(c_sel), .sin_lsb(ca_hi), .sin_msb(c_sm),
        .oe_a_n(1'b1), .oe_b_n(1'b1), .pio_in('0), .pio_out(cb_out),
        .pio_oe(cb_oe), .q_lo(cb_lo), .q_hi(cb_hi)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0]  exp_w, nxt_w;
        logic [15:0]   cexp;
        logic [7:0]    lfsr;
        clr_n = 1'b0; sel = 2'b00; sin_lsb = 1'b0; sin_msb = 1'b0;
        oe_a_n = 1'b1; oe_b_n = 1'b1; ext_drive = '0;
        c_sel = 2'b00; c_sl = 1'b0; c_sm = 1'b0;
        lfsr = 8'h5B;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset word", 32'(pio_out), 0);
        chk("R1", "reset end bits", {30'd0, q_hi, q_lo}, 0);
        @(negedge clk);
        clr_n = 1'b1;
        exp_w = '0;

        // sweep: modes in order load, hold, up, down; all enable pairs
        for (int mi = 0; mi < 4; mi++) begin
            for (int e = 0; e < 4; e++) begin
                for (int k = 0; k < 16; k++) begin
                    int m;
                    m = (mi + 3) % 4;
                    @(negedge clk);
                    sel = 2'(m);
                    {oe_a_n, oe_b_n} = 2'(e);
                    ext_drive = 8'(k * 29) ^ lfsr;
                    sin_lsb = lfsr[0];
                    sin_msb = lfsr[5];
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    #1;
                    chk("R6", "drive enable", {31'd0, pio_oe}, {31'd0, (e == 0) && (m != 3)});
                    case (m)
                        0: nxt_w = exp_w;
                        1: nxt_w = {exp_w[W-2:0], sin_lsb};
                        2: nxt_w = {sin_msb, exp_w[W-1:1]};
                        default: nxt_w = ext_drive;
                    endcase
                    @(posedge clk);
                    #1;
                    exp_w = nxt_w;
                    chk(tag_of(m), (e != 0) ? "word, port off (R8)" : "word",
                        32'(pio_out), 32'(exp_w));
                    chk("R7", "end bits", {30'd0, q_hi, q_lo}, {30'd0, exp_w[W-1], exp_w[0]});
                end
            end
        end

        // clear in the middle of a shift
        @(negedge clk);
        sel = 2'b11; ext_drive = 8'hA5; oe_a_n = 1'b0; oe_b_n = 1'b0;
        @(negedge clk);
        sel = 2'b01; sin_lsb = 1'b1;
        @(posedge clk);
        #3;
        chk("R3", "word before clear", 32'(pio_out), 32'h4B);
        clr_n = 1'b0;
        #1;
        chk("R1", "cleared between edges", 32'(pio_out), 0);
        @(negedge clk);
        sel = 2'b11; ext_drive = 8'hFF;
        @(posedge clk);
        #1;
        chk("R1", "clear overrides load", 32'(pio_out), 0);
        @(negedge clk);
        clr_n = 1'b1; sel = 2'b01; sin_lsb = 1'b1;
        @(posedge clk);
        #1;
        chk("R3", "shift after clear", 32'(pio_out), 1);

        // chained pair: upward then downward across 16 bits
        cexp = '0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            c_sel = 2'b01;
            c_sl = (t % 3 == 0) || (t % 5 == 1);
            cexp = {cexp[14:0], c_sl};
            @(posedge clk);
            #1;
            chk("R8", "chain up", {16'd0, cb_out, ca_out}, {16'd0, cexp});
            chk("R7", "chain end bits", {30'd0, cb_hi, ca_lo}, {30'd0, cexp[15], cexp[0]});
        end
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            c_sel = 2'b10;
            c_sm = (t % 4 == 2) || (t % 7 == 0);
            cexp = {c_sm, cexp[15:1]};
            @(posedge clk);
            #1;
            chk("R8", "chain down", {16'd0, cb_out, ca_out}, {16'd0, cexp});
            chk("R4", "chain port idle", {30'd0, ca_oe, cb_oe}, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule